// File: doc/BRIEF.md
# Double-Buffered SPI Master with Baud Divider

This block is a full-duplex serial master for a three-wire synchronous link. It always drives the serial clock (`spi_sck`), shifts a byte out on `spi_mosi` and, on the same clock, samples a byte in on `spi_miso`. The serial clock period comes from a programmable divider value N: each half period lasts N+1 system clocks, so the serial clock runs at f_clk / (2·(N+1)). The fastest rate is half the system clock, at N = 0. Clock polarity and phase can be set independently, which covers all four SPI modes. One bit selects the order of the frame, least or most significant bit first, and that order applies to both directions. No parity and no start or stop framing are added.

The transmit side has two stages. A one-byte holding buffer sits in front of the shift register. The host writes into the buffer while the previous byte is still shifting. When the byte in flight ends and the buffer is full, the next byte starts with no idle gap. The host sees three flags: transmit buffer empty, transmit complete and receive full. Each flag has its own interrupt enable. The received byte is held in a read register until the next byte completes.

A three-state controller sequences each byte. The states are IDLE (no transfer), LEAD (first half of a bit) and TRAIL (second half of a bit). START moves from IDLE to LEAD when the transmitter is enabled and the buffer holds a byte. HALF moves from LEAD to TRAIL on a divider tick. NEXT_BIT moves from TRAIL to LEAD on a tick that is not the last bit. RELOAD moves from TRAIL to LEAD on the last bit's tick when a buffered byte is ready. FINISH moves from TRAIL to IDLE on the last bit's tick otherwise.

Top module: `sync_spi_master`

## Requirements
- R1: While `rst_n` is low, the outputs read as follows: `spi_sck` = 0, `spi_mosi` = 0, `tx_empty` = 1, `tx_done` = 0, `rx_full` = 0, `rd_data` = 0.
- R2: In IDLE, `spi_sck` follows `cpol` one clock later. `spi_mosi` keeps the last bit that was sent.
- R3: During a transfer, `spi_sck` is at `cpol` XOR `cpha` in the LEAD half of every bit and at its inverse in the TRAIL half. So `cpha` = 0 samples on the leading edge and `cpha` = 1 samples on the trailing edge. `spi_mosi` changes only when a bit starts. `spi_miso` is sampled at the end of the LEAD half.
- R4: With `lsb_first` = 1, bit 0 is sent first and the first bit received lands in bit 0. With `lsb_first` = 0, bit 7 is sent first and the first bit received lands in bit 7.
- R5: A write (`wr_valid` high at a clock edge) is taken only when `tx_en` = 1 and `tx_empty` = 1. Any other write is ignored and leaves the pending data unchanged. A byte can be written while the previous byte is shifting.
- R6: Each half of a serial clock period lasts `baud_div`+1 clocks, so one byte takes 16·(`baud_div`+1) clocks. The divider value is captured when a byte starts, and a later change applies only from the next byte.
- R7: A buffered byte starts on the same edge that ends the previous byte. Two back-to-back bytes take 32·(N+1) clocks from the first START to the second FINISH.
- R8: `tx_empty` clears on an accepted write. It sets on the edge where the buffer moves into the shift register.
- R9: `tx_done` sets when a byte ends with the buffer empty. It clears on an accepted write.
- R10: When a byte ends with `rx_en` = 1, `rd_data` takes the received byte and `rx_full` sets. A `rd_ack` pulse clears `rx_full`. When a byte ends with `rx_en` = 0, `rd_data` and `rx_full` are left unchanged.
- R11: Each interrupt output is its flag ANDed with its enable: `irq_tx_empty`, `irq_tx_done` and `irq_rx_full`.
- R12: While `tx_en` = 0, no transfer starts and `spi_sck` stays at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable: gates writes and the start of transfers |
| rx_en | input | 1 | Receive enable: gates the capture of received bytes |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0 = sample on the leading edge, 1 = sample on the trailing edge |
| lsb_first | input | 1 | 1 = least significant bit first, 0 = most significant bit first |
| baud_div | input | 12 | Divider value N |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| rd_ack | input | 1 | Read acknowledge; clears `rx_full` |
| rd_data | output | 8 | Last received byte |
| tx_empty | output | 1 | Holding buffer is empty |
| tx_done | output | 1 | Transmission complete with the buffer empty |
| rx_full | output | 1 | A new received byte is waiting |
| ie_tx_empty | input | 1 | Interrupt enable for `tx_empty` |
| ie_tx_done | input | 1 | Interrupt enable for `tx_done` |
| ie_rx_full | input | 1 | Interrupt enable for `rx_full` |
| irq_tx_empty | output | 1 | Buffer-empty interrupt |
| irq_tx_done | output | 1 | Transmit-complete interrupt |
| irq_rx_full | output | 1 | Receive-full interrupt |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions assume that `cpol`, `cpha` and `lsb_first` stay constant while a byte is in flight. They also assume that `spi_miso` is stable from the shift edge of the peer until the sampling edge. The bench changes configuration only after the controller has returned to IDLE, and it keeps the modelled peer silent while it does so. The bench's peer model updates `spi_miso` only on the shift edge of the selected mode, so the value is steady for at least one full half period before it is sampled.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } spim_state_e;

    // Serial clock level for a given controller state.
    function automatic logic sck_level(spim_state_e st, logic pol, logic pha);
        logic lvl;
        unique case (st)
            ST_LEAD:  lvl = pol ^ pha;
            ST_TRAIL: lvl = ~(pol ^ pha);
            default:  lvl = pol;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
            lim_q <= div_in;
        end else if (run) begin
            if (cnt_q == lim_q) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign tick = run && (cnt_q == lim_q);

    // R6: the half-period counter never passes the captured divider value
    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= lim_q));

    // R6: a divider change does not reach the running count until a restart
    p_limit_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(lim_q));

endmodule

// File: rtl/spim_tx_path.sv
module spim_tx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsb_first,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    input  logic              shift,
    output logic              buf_full,
    output logic              mosi
);

    logic [DATA_W-1:0] hold_q;
    logic              full_q;
    logic [DATA_W-1:0] sh_q;
    logic              mosi_q;
    logic [DATA_W-1:0] sh_next;

    always_comb begin
        if (lsb_first) begin
            sh_next = {1'b0, sh_q[DATA_W-1:1]};
        end else begin
            sh_next = {sh_q[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (wr_en) begin
                hold_q <= wr_data;
                full_q <= 1'b1;
            end else if (load) begin
                full_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            mosi_q <= 1'b0;
        end else if (load) begin
            sh_q   <= hold_q;
            mosi_q <= lsb_first ? hold_q[0] : hold_q[DATA_W-1];
        end else if (shift) begin
            sh_q   <= sh_next;
            mosi_q <= lsb_first ? sh_next[0] : sh_next[DATA_W-1];
        end
    end

    assign buf_full = full_q;
    assign mosi     = mosi_q;

    // R5: the shift register is only loaded from a filled buffer
    p_load_from_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> full_q);

    // R5: pending data survives until it is moved into the shifter
    p_hold_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !load) |=> (full_q && $stable(hold_q)));

    // R3: data out moves only at a bit boundary
    p_mosi_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(mosi_q));

endmodule

// File: rtl/spim_rx_path.sv
module spim_rx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsb_first,
    input  logic              sample,
    input  logic              miso,
    input  logic              latch,
    input  logic              rd_clear,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_full
);

    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] rd_q;
    logic              full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (sample) begin
            if (lsb_first) begin
                sh_q <= {miso, sh_q[DATA_W-1:1]};
            end else begin
                sh_q <= {sh_q[DATA_W-2:0], miso};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q   <= '0;
            full_q <= 1'b0;
        end else begin
            if (latch) begin
                rd_q <= sh_q;
            end
            if (latch) begin
                full_q <= 1'b1;
            end else if (rd_clear) begin
                full_q <= 1'b0;
            end
        end
    end

    assign rd_data = rd_q;
    assign rx_full = full_q;

    // R10: the read register changes only when a byte is captured
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(rd_q));

    // R10: an acknowledge without a new capture empties the flag
    p_rd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !latch) |=> !full_q);

    // R3: sampling and capture never coincide
    p_sample_latch_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample && latch));

endmodule

// File: rtl/sync_spi_master.sv
module sync_spi_master
    import spim_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_empty,
    output logic              tx_done,
    output logic              rx_full,
    input  logic              ie_tx_empty,
    input  logic              ie_tx_done,
    input  logic              ie_rx_full,
    output logic              irq_tx_empty,
    output logic              irq_tx_done,
    output logic              irq_rx_full,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    spim_state_e state_q;
    spim_state_e state_d;

    logic [CNT_W-1:0] bit_q;
    logic             sck_q;
    logic             done_q;
    logic             tick;
    logic             buf_full;
    logic             wr_accept;
    logic             start;
    logic             end_byte;
    logic             reload;
    logic             load;
    logic             shift_en;
    logic             sample;
    logic             latch;

    assign wr_accept = wr_valid && tx_en && !buf_full;
    assign start     = (state_q == ST_IDLE) && tx_en && buf_full;
    assign end_byte  = (state_q == ST_TRAIL) && tick && (bit_q == LAST_BIT);
    assign reload    = end_byte && tx_en && buf_full;
    assign load      = start || reload;
    assign shift_en  = (state_q == ST_TRAIL) && tick && (bit_q != LAST_BIT);
    assign sample    = (state_q == ST_LEAD) && tick;
    assign latch     = end_byte && rx_en;

    spim_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q != ST_IDLE),
        .restart (load),
        .div_in  (baud_div),
        .tick    (tick)
    );

    spim_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .lsb_first (lsb_first),
        .wr_en     (wr_accept),
        .wr_data   (wr_data),
        .load      (load),
        .shift     (shift_en),
        .buf_full  (buf_full),
        .mosi      (spi_mosi)
    );

    spim_rx_path #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .lsb_first (lsb_first),
        .sample    (sample),
        .miso      (spi_miso),
        .latch     (latch),
        .rd_clear  (rd_ack),
        .rd_data   (rd_data),
        .rx_full   (rx_full)
    );

    // Next-state logic: START, HALF, NEXT_BIT, RELOAD, FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    state_d = ST_TRAIL;
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    if (bit_q != LAST_BIT) begin
                        state_d = ST_LEAD;
                    end else if (reload) begin
                        state_d = ST_LEAD;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs and bit bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            bit_q  <= '0;
            done_q <= 1'b0;
        end else begin
            sck_q <= sck_level(state_d, cpol, cpha);
            if (load) begin
                bit_q <= '0;
            end else if (shift_en) begin
                bit_q <= bit_q + 1'b1;
            end
            if (wr_accept) begin
                done_q <= 1'b0;
            end else if (end_byte && !reload) begin
                done_q <= 1'b1;
            end
        end
    end

    assign spi_sck      = sck_q;
    assign tx_empty     = !buf_full;
    assign tx_done      = done_q;
    assign irq_tx_empty = tx_empty && ie_tx_empty;
    assign irq_tx_done  = done_q && ie_tx_done;
    assign irq_rx_full  = rx_full && ie_rx_full;

    // R9: completion is only reported while the controller rests
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == ST_IDLE));

    // R6: during a transfer the serial clock moves only on a divider tick
    p_sck_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && !tick) |=> $stable(sck_q));

    // R12: with the transmitter disabled the controller stays idle
    p_no_start_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !tx_en) |=> (state_q == ST_IDLE));

endmodule

// File: tb/sync_spi_master_test.sv
`timescale 1ns/1ps
module sync_spi_master_test;

    localparam real TCLK = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b1;
    logic        rx_en = 1'b1;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic        lsb_first = 1'b0;
    logic [11:0] baud_div = 12'd0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        rd_ack = 1'b0;
    logic [7:0]  rd_data;
    logic        tx_empty, tx_done, rx_full;
    logic        ie_tx_empty = 1'b0, ie_tx_done = 1'b0, ie_rx_full = 1'b0;
    logic        irq_tx_empty, irq_tx_done, irq_rx_full;
    logic        spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;

    sync_spi_master uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first), .baud_div(baud_div),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_ack(rd_ack), .rd_data(rd_data),
        .tx_empty(tx_empty), .tx_done(tx_done), .rx_full(rx_full),
        .ie_tx_empty(ie_tx_empty), .ie_tx_done(ie_tx_done), .ie_rx_full(ie_rx_full),
        .irq_tx_empty(irq_tx_empty), .irq_tx_done(irq_tx_done), .irq_rx_full(irq_rx_full),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #(TCLK / 2.0) clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Scoreboard queues
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];
    logic [7:0] slv_q[$];

    // Peer model
    bit         slv_on = 1'b0;
    int         slv_idx = 0;
    int         cap_cnt = 0;
    logic [7:0] cap = 8'h00;
    logic       lead_e;
    bit         mon_on = 1'b1;
    bit         rd_req = 1'b0;

    function automatic logic pick(input logic [7:0] b, input int k);
        return lsb_first ? b[k] : b[7-k];
    endfunction

    always @(spi_sck) begin
        if (slv_on) begin
            lead_e = (spi_sck != cpol);
            if (lead_e == !cpha) begin
                // capture edge (R3: leading for cpha 0, trailing for cpha 1)
                cap = lsb_first ? {spi_mosi, cap[7:1]} : {cap[6:0], spi_mosi};
                cap_cnt++;
                if (cap_cnt == 8) begin
                    cap_cnt = 0;
                    if (exp_tx.size() == 0) begin
                        check_eq("R5", "unexpected byte on data out", cap, -1);
                    end else begin
                        check_eq("R4", "byte seen on data out (R3 timing)", cap, exp_tx.pop_front());
                    end
                end
            end else begin
                if (cpha) begin
                    spi_miso = (slv_q.size() != 0) ? pick(slv_q[0], slv_idx) : 1'b0;
                    slv_idx++;
                    if (slv_idx == 8) begin
                        slv_idx = 0;
                        if (slv_q.size() != 0) void'(slv_q.pop_front());
                    end
                end else begin
                    slv_idx++;
                    if (slv_idx == 8) begin
                        slv_idx = 0;
                        if (slv_q.size() != 0) void'(slv_q.pop_front());
                    end
                    spi_miso = (slv_q.size() != 0) ? pick(slv_q[0], slv_idx) : 1'b0;
                end
            end
        end
    end

    // Receive monitor: compares the read register and acknowledges it
    always @(negedge clk) begin
        if (rd_ack) begin
            rd_ack = 1'b0;
        end else if (rd_req) begin
            rd_ack = 1'b1;
            rd_req = 1'b0;
        end else if (mon_on && rx_full && rst_n) begin
            if (exp_rx.size() == 0) begin
                check_eq("R10", "unexpected received byte", rd_data, -1);
            end else begin
                check_eq("R10", "received byte", rd_data, exp_rx.pop_front());
            end
            rd_ack = 1'b1;
        end
    end

    task automatic send_byte(input logic [7:0] tx, input logic [7:0] rx, input bit want_rx);
        slv_q.push_back(rx);
        exp_tx.push_back(tx);
        if (want_rx) exp_rx.push_back(rx);
        if (!cpha && slv_q.size() == 1 && slv_idx == 0) spi_miso = pick(rx, 0);
        do @(negedge clk); while (!tx_empty);
        wr_data  = tx;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(tx_done && exp_tx.size() == 0));
        repeat (3) @(negedge clk);
    endtask

    task automatic configure(input logic p, input logic h, input logic l, input int n);
        slv_on = 1'b0;
        cpol = p; cpha = h; lsb_first = l; baud_div = 12'(n);
        repeat (3) @(negedge clk);
        slv_idx = 0; cap_cnt = 0; cap = 8'h00;
        slv_q.delete();
        spi_miso = 1'b0;
        slv_on = 1'b1;
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        real t0, t1;
        logic [7:0] b1, b2, prev;

        repeat (4) @(negedge clk);
        // R1: reset state
        check_eq("R1", "sck in reset", spi_sck, 0);
        check_eq("R1", "mosi in reset", spi_mosi, 0);
        check_eq("R1", "tx_empty in reset", tx_empty, 1);
        check_eq("R1", "tx_done in reset", tx_done, 0);
        check_eq("R1", "rx_full in reset", rx_full, 0);
        check_eq("R1", "rd_data in reset", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R7: every mode and order, two bytes back to back
        for (int m = 0; m < 8; m++) begin
            configure(m[0], m[1], m[2], 1);
            b1 = 8'(8'h3C ^ (m * 29));
            b2 = 8'(8'hC5 + (m * 17));
            send_byte(b1, b1 ^ 8'h5A, 1'b1);
            send_byte(b2, ~b2, 1'b1);
            wait_idle();
            check_eq("R2", "idle sck level", spi_sck, cpol);
            check_eq("R2", "mosi holds last bit", spi_mosi, lsb_first ? b2[7] : b2[0]);
            check_eq("R10", "all received bytes seen", exp_rx.size(), 0);
        end

        // R6: byte length with divider 3, divider change mid-byte ignored
        configure(1'b0, 1'b0, 1'b0, 3);
        send_byte(8'hA5, 8'h0F, 1'b1);
        t0 = $realtime - TCLK / 2.0;
        check_eq("R9", "tx_done cleared by write", tx_done, 0);
        @(negedge clk);
        baud_div = 12'd0;
        @(posedge tx_done);
        t1 = $realtime;
        check_eq("R6", "byte length ns (N=3)", int'(t1 - t0), int'((1 + 16 * 4) * TCLK));
        wait_idle();

        // R6: serial clock period at N = 0
        send_byte(8'h96, 8'h69, 1'b1);
        @(posedge spi_sck);
        t0 = $realtime;
        @(posedge spi_sck);
        t1 = $realtime;
        check_eq("R6", "sck period ns (N=0)", int'(t1 - t0), int'(2 * TCLK));
        wait_idle();

        // R7: two buffered bytes with no gap at N = 2
        baud_div = 12'd2;
        send_byte(8'h12, 8'hED, 1'b1);
        t0 = $realtime - TCLK / 2.0;
        send_byte(8'h34, 8'hCB, 1'b1);
        @(posedge tx_done);
        t1 = $realtime;
        check_eq("R7", "two-byte length ns (N=2)", int'(t1 - t0), int'((1 + 32 * 3) * TCLK));
        wait_idle();

        // R12: transmitter disabled
        tx_en = 1'b0;
        @(negedge clk);
        wr_data = 8'h77; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        repeat (40) @(negedge clk);
        check_eq("R12", "tx_empty with tx disabled", tx_empty, 1);
        check_eq("R12", "sck idle with tx disabled", spi_sck, cpol);
        check_eq("R12", "tx_done unchanged", tx_done, 1);
        tx_en = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R5", "write while disabled left nothing pending", tx_empty, 1);

        // R5 R8: write into a full buffer is dropped
        configure(1'b1, 1'b1, 1'b1, 7);
        send_byte(8'h5C, 8'hA3, 1'b1);
        check_eq("R8", "tx_empty clear after write", tx_empty, 0);
        @(negedge clk);
        check_eq("R8", "tx_empty set on move to shifter", tx_empty, 1);
        send_byte(8'hE1, 8'h1E, 1'b1);
        check_eq("R5", "buffer full while shifting", tx_empty, 0);
        wr_data = 8'hFF; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        check_eq("R5", "no partial extra byte", cap_cnt, 0);
        check_eq("R5", "buffer empty at end", tx_empty, 1);

        // R10: receiver disabled leaves the read register alone
        rx_en = 1'b0;
        prev = rd_data;
        send_byte(8'h5E, 8'hC3, 1'b0);
        wait_idle();
        check_eq("R10", "rd_data kept with rx disabled", rd_data, prev);
        check_eq("R10", "rx_full stays clear with rx disabled", rx_full, 0);
        rx_en = 1'b1;

        // R11: interrupt gating
        mon_on = 1'b0;
        ie_tx_empty = 1'b1; ie_tx_done = 1'b1; ie_rx_full = 1'b1;
        #1;
        check_eq("R11", "irq_tx_empty", irq_tx_empty, 1);
        check_eq("R11", "irq_tx_done", irq_tx_done, 1);
        check_eq("R11", "irq_rx_full idle", irq_rx_full, 0);
        send_byte(8'h81, 8'h42, 1'b0);
        wait_idle();
        check_eq("R10", "rx_full set", rx_full, 1);
        check_eq("R10", "rd_data captured", rd_data, 8'h42);
        check_eq("R11", "irq_rx_full enabled", irq_rx_full, 1);
        ie_rx_full = 1'b0; ie_tx_done = 1'b0;
        #1;
        check_eq("R11", "irq_rx_full masked", irq_rx_full, 0);
        check_eq("R11", "irq_tx_done masked", irq_tx_done, 0);
        rd_req = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R10", "rx_full cleared by ack", rx_full, 0);

        finished = 1'b1;
        report();
    end

endmodule